// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block is the transmit half of an asynchronous serial port. It takes one byte at a time through a valid/ready handshake into a single-entry holding register. When the frame shifter is free, the byte moves into the shifter. The shifter then drives a frame onto `txd`: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. A 6-bit line-control word sets the frame shape and a baud divisor sets the speed. The block reads both when a byte enters the shifter and holds them for the whole of that frame.

Bit timing follows the usual 16x-oversampled scheme. An optional prescaler of `REF_DIV` core clocks gives the reference tick. A divisor counter turns that tick into the 16x tick, and sixteen 16x ticks make one bit. One bit therefore lasts 16·REF_DIV·divisor clock cycles. With a 1.8432 MHz reference, a divisor of 1 gives 115200 baud and a divisor of 12 gives 9600 baud. Because the holding register empties as soon as its byte enters the shifter, software can queue the next byte during a frame. Frames then follow each other with no idle gap.

Top module: `uart_tx_frame`

## Requirements
- R1: After synchronous reset, `txd` is 1 and `hold_empty`, `tx_empty` and `in_ready` are all 1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` and `hold_empty` are 0 from the next cycle until the byte leaves the holding register. A byte offered while `in_ready` is 0 is dropped and never sent.
- R3: A frame starts with one low start bit, followed by the data bits least significant first. `line_ctrl[1:0]` sets the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length are not sent. The line is high while no frame is being sent.
- R4: Each bit lasts 16·REF_DIV·D clock cycles, where D is `baud_div`. A divisor of 0 stands for 2^DIV_W.
- R5: `line_ctrl[5:3]` sets the parity bit that follows the data. Codes with bit 3 clear give no parity bit. 001 is odd (the count of ones over data and parity is odd), 011 is even, 101 always sends 1 and 111 always sends 0. Parity covers only the data bits that are sent.
- R6: One high stop bit ends the frame, or two when `line_ctrl[2]` is 1.
- R7: `hold_empty` rises on the edge where the byte moves into the shifter, which is the edge where the start bit begins. This happens one cycle after acceptance if the shifter is idle. If a byte is waiting when the last stop bit ends, its start bit follows at once with no idle cycle.
- R8: `tx_empty` falls on the edge after a byte is accepted. It rises at the end of the last stop bit if no byte is waiting.
- R9: `line_ctrl` and `baud_div` are read when a byte enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ctrl | input | 6 | Frame shape: word length [1:0], two stop bits [2], parity mode [5:3] |
| baud_div | input | DIV_W | Baud divisor; 0 means 2^DIV_W |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The hardest case to reach from the ports is the hand-over at the last stop bit. Here a second byte is already waiting, the next start bit must begin on the very edge the stop bit ends, and a third byte offered against a full holding register must vanish. The bench runs the first frame check in parallel with a stimulus thread. That thread queues the second byte and pushes the rejected third byte while the first frame is still on the line. The wrap-around divisor value cannot be timed on the default width within the run budget, so a second instance with a 4-bit divisor is used to time a bit at divisor 0.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(input logic [5:0] lc, input logic [7:0] d);
        frame_cfg_t c;
        c.data      = d;
        c.wlen      = lc[1:0];
        c.two_stop  = lc[2];
        c.par_en    = lc[3];
        c.par_even  = lc[4];
        c.par_stick = lc[5];
        return c;
    endfunction

    // index of the last data bit: word length 5..8 maps to 4..7
    function automatic logic [2:0] last_index(input logic [1:0] wlen);
        return {1'b1, wlen};
    endfunction

    function automatic logic parity_of(input frame_cfg_t c);
        logic [7:0] masked;
        masked = c.data & (8'hFF >> (2'd3 - c.wlen));
        if (c.par_stick)
            return ~c.par_even;
        else if (c.par_even)
            return ^masked;
        else
            return ~(^masked);
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       take,
    output logic       hold_empty,
    output logic [7:0] hold_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_empty <= 1'b1;
            hold_data  <= '0;
        end else if (in_valid && hold_empty) begin
            hold_data  <= in_data;
            hold_empty <= 1'b0;
        end else if (take) begin
            hold_empty <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W   = 16,
    parameter int REF_DIV = 1,
    parameter int OVS     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end
);

    localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam int SUB_W = $clog2(OVS);

    logic             clear;
    logic             ref_tick;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic [SUB_W-1:0] sub_cnt;
    logic             x16_tick;

    assign clear    = rst || restart || !run;
    assign div_last = div - 1'b1;   // divisor 0 wraps to the full range

    generate
        if (REF_DIV > 1) begin : g_pre
            logic [REF_W-1:0] ref_cnt;
            always_ff @(posedge clk) begin
                if (clear)
                    ref_cnt <= '0;
                else if (ref_cnt == REF_W'(REF_DIV - 1))
                    ref_cnt <= '0;
                else
                    ref_cnt <= ref_cnt + 1'b1;
            end
            assign ref_tick = (ref_cnt == REF_W'(REF_DIV - 1));
        end else begin : g_nopre
            assign ref_tick = 1'b1;
        end
    endgenerate

    assign x16_tick = ref_tick && (div_cnt == div_last);
    assign bit_end  = run && x16_tick && (sub_cnt == SUB_W'(OVS - 1));

    always_ff @(posedge clk) begin
        if (clear) begin
            div_cnt <= '0;
            sub_cnt <= '0;
        end else if (ref_tick) begin
            if (div_cnt == div_last) begin
                div_cnt <= '0;
                sub_cnt <= (sub_cnt == SUB_W'(OVS - 1)) ? '0 : sub_cnt + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_empty,
    input  logic [7:0]       hold_data,
    input  logic [5:0]       line_ctrl,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             bit_end,
    output logic             take,
    output logic             busy,
    output logic [DIV_W-1:0] div_q,
    output logic             txd
);

    tx_state_e  state;
    frame_cfg_t cfg;
    logic [7:0] shreg;
    logic [2:0] bit_cnt;
    logic       stop_cnt;
    logic       stop_last;

    assign busy      = (state != ST_IDLE);
    assign stop_last = (state == ST_STOP) && bit_end && (stop_cnt == cfg.two_stop);
    assign take      = !hold_empty && (!busy || stop_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '0;
            shreg    <= '0;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
            div_q    <= '0;
            txd      <= 1'b1;
        end else if (take) begin
            cfg      <= decode_cfg(line_ctrl, hold_data);
            shreg    <= hold_data;
            div_q    <= baud_div;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
            state    <= ST_START;
            txd      <= 1'b0;
        end else if (busy && bit_end) begin
            case (state)
                ST_START: begin
                    txd     <= shreg[0];
                    shreg   <= shreg >> 1;
                    bit_cnt <= '0;
                    state   <= ST_DATA;
                end
                ST_DATA: begin
                    if (bit_cnt == last_index(cfg.wlen)) begin
                        if (cfg.par_en) begin
                            txd   <= parity_of(cfg);
                            state <= ST_PARITY;
                        end else begin
                            txd   <= 1'b1;
                            state <= ST_STOP;
                        end
                    end else begin
                        txd     <= shreg[0];
                        shreg   <= shreg >> 1;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    txd      <= 1'b1;
                    stop_cnt <= 1'b0;
                    state    <= ST_STOP;
                end
                ST_STOP: begin
                    if (stop_cnt == cfg.two_stop)
                        state <= ST_IDLE;
                    else
                        stop_cnt <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
    parameter int DIV_W   = 16,
    parameter int REF_DIV = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       line_ctrl,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_empty
);

    logic [7:0]       hold_data;
    logic             take;
    logic             busy;
    logic             bit_end;
    logic [DIV_W-1:0] div_q;

    uart_tx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .take       (take),
        .hold_empty (hold_empty),
        .hold_data  (hold_data)
    );

    uart_tx_shift #(.DIV_W(DIV_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .hold_empty (hold_empty),
        .hold_data  (hold_data),
        .line_ctrl  (line_ctrl),
        .baud_div   (baud_div),
        .bit_end    (bit_end),
        .take       (take),
        .busy       (busy),
        .div_q      (div_q),
        .txd        (txd)
    );

    uart_tx_baud #(.DIV_W(DIV_W), .REF_DIV(REF_DIV)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (take),
        .div     (div_q),
        .bit_end (bit_end)
    );

    assign in_ready = hold_empty;
    assign tx_empty = hold_empty && !busy;

endmodule

// File: rtl/uart_tx_frame_chk.sv
module uart_tx_frame_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty
);

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !hold_empty) else $error("accept did not fill"); // R2

    AST_EMPTY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_empty) |-> $past(in_valid && in_ready)) else $error("tx_empty fell without accept"); // R8

    AST_HANDOVER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_empty) |-> !txd) else $error("hand-over without start bit"); // R7

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd) else $error("line low while empty"); // R3

    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst)
        tx_empty |=> txd) else $error("start bit straight from empty"); // R3

    AST_STOP_BEFORE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> $past(txd)) else $error("frame ended without stop level"); // R6

endmodule

bind uart_tx_frame uart_tx_frame_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/uart_tx_frame_test.sv
module uart_tx_frame_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  lc;
    logic [15:0] dv;
    logic        iv;
    logic [7:0]  id;
    logic        ir, txd, he, te;

    logic [3:0]  s_dv;
    logic        s_iv;
    logic        s_ir, s_txd, s_he, s_te;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_tx_frame uut (
        .clk(clk), .rst(rst), .line_ctrl(lc), .baud_div(dv),
        .in_valid(iv), .in_data(id), .in_ready(ir), .txd(txd),
        .hold_empty(he), .tx_empty(te)
    );

    uart_tx_frame #(.DIV_W(4)) uut_small (
        .clk(clk), .rst(rst), .line_ctrl(lc), .baud_div(s_dv),
        .in_valid(s_iv), .in_data(id), .in_ready(s_ir), .txd(s_txd),
        .hold_empty(s_he), .tx_empty(s_te)
    );

    // {line_ctrl[5:0], divisor[15:0], data[7:0]}
    localparam int NVEC = 9;
    localparam logic [29:0] VEC [NVEC] = '{
        {6'b000011, 16'd1, 8'hA5},
        {6'b001011, 16'd2, 8'h3C},
        {6'b011011, 16'd1, 8'h3D},
        {6'b101000, 16'd1, 8'hFF},
        {6'b111001, 16'd3, 8'h2A},
        {6'b000110, 16'd1, 8'h55},
        {6'b011111, 16'd1, 8'h00},
        {6'b001010, 16'd1, 8'h80},
        {6'b010011, 16'd2, 8'h81}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period(input logic [15:0] d);
        return 16 * ((d == 16'd0) ? 65536 : int'(d));
    endfunction

    function automatic void build(input logic [5:0] l, input logic [7:0] d,
                                  output bit [11:0] b, output int n);
        int wl;
        int ones;
        b = '0;
        n = 0;
        b[n] = 1'b0; n++;
        wl = 5 + int'(l[1:0]);
        ones = 0;
        for (int i = 0; i < wl; i++) begin
            b[n] = d[i]; n++;
            if (d[i]) ones++;
        end
        if (l[3]) begin
            case (l[5:4])
                2'b00: b[n] = (ones % 2 == 0);
                2'b01: b[n] = (ones % 2 == 1);
                2'b10: b[n] = 1'b1;
                default: b[n] = 1'b0;
            endcase
            n++;
        end
        b[n] = 1'b1; n++;
        if (l[2]) begin
            b[n] = 1'b1; n++;
        end
    endfunction

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        id = d;
        iv = 1'b1;
        while (ir !== 1'b1) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        iv = 1'b0;
    endtask

    task automatic expect_frame(input logic [5:0] l, input logic [15:0] d,
                                input logic [7:0] data, input string req,
                                input bit more, input bit scramble);
        bit [11:0] b;
        int n;
        int p;
        int cur;
        int guard;
        p = period(d);
        build(l, data, b, n);
        guard = 0;
        while (txd !== 1'b0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(txd === 1'b0, "R3", "start bit seen", int'(txd), 0);
        if (scramble) begin
            lc = ~l;
            dv = d + 16'd3;
        end
        cur = 0;
        for (int k = 0; k < n; k++) begin
            int target;
            target = k * p + p / 2;
            repeat (target - cur) @(negedge clk);
            cur = target;
            chk(txd === b[k], req, $sformatf("bit %0d of frame", k), int'(txd), int'(b[k]));
        end
        repeat (n * p - 1 - cur) @(negedge clk);
        chk(te === 1'b0 && txd === 1'b1, "R8", "busy during last stop cycle",
            int'({te, txd}), 1);
        @(negedge clk);
        if (more)
            chk(txd === 1'b0, "R7", "next start follows stop at once", int'(txd), 0);
        else
            chk(txd === 1'b1 && te === 1'b1, "R8", "empty after last stop",
                int'({te, txd}), 3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        rst  = 1'b1;
        lc   = 6'b000011;
        dv   = 16'd1;
        iv   = 1'b0;
        id   = 8'h00;
        s_dv = 4'd0;
        s_iv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(he === 1'b1 && ir === 1'b1, "R1", "hold empty/ready after reset",
            int'({he, ir}), 3);
        chk(te === 1'b1, "R1", "tx_empty after reset", int'(te), 1);

        // table walk: R3 word lengths, R5 parity modes, R6 stop bits
        for (int v = 0; v < NVEC; v++) begin
            logic [5:0]  l;
            logic [15:0] d;
            logic [7:0]  x;
            {l, d, x} = VEC[v];
            lc = l;
            dv = d;
            send(x);
            expect_frame(l, d, x, "R3 R5 R6", 1'b0, 1'b0);
        end

        // R4 bit duration at divisor 5
        lc = 6'b000011;
        dv = 16'd5;
        send(8'h01);
        while (txd !== 1'b0) @(negedge clk);
        repeat (79) @(negedge clk);
        chk(txd === 1'b0, "R4", "start bit still low at cycle 79", int'(txd), 0);
        @(negedge clk);
        chk(txd === 1'b1, "R4", "data bit 0 at cycle 80", int'(txd), 1);
        while (te !== 1'b1) @(negedge clk);

        // R4 divisor 0 on the 4-bit divisor instance: 16*16 cycles per bit
        @(negedge clk);
        id   = 8'h01;
        s_iv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_iv = 1'b0;
        while (s_txd !== 1'b0) @(negedge clk);
        repeat (255) @(negedge clk);
        chk(s_txd === 1'b0, "R4", "divisor 0 start bit at cycle 255", int'(s_txd), 0);
        @(negedge clk);
        chk(s_txd === 1'b1, "R4", "divisor 0 data bit at cycle 256", int'(s_txd), 1);

        // R2/R7/R8 hand-over with a queued byte and a rejected third byte
        lc = 6'b000011;
        dv = 16'd2;
        send(8'hC3);
        chk(he === 1'b0 && ir === 1'b0, "R2", "holding full after accept",
            int'({he, ir}), 0);
        chk(te === 1'b0, "R8", "tx_empty low after accept", int'(te), 0);
        fork
            begin
                expect_frame(6'b000011, 16'd2, 8'hC3, "R7", 1'b1, 1'b0);
                expect_frame(6'b000011, 16'd2, 8'h5A, "R7", 1'b0, 1'b0);
            end
            begin
                @(negedge clk);
                chk(he === 1'b1 && txd === 1'b0, "R7", "hold empties as start begins",
                    int'({he, txd}), 2);
                send(8'h5A);
                chk(ir === 1'b0, "R2", "not ready while second byte waits", int'(ir), 0);
                id = 8'hEE;
                iv = 1'b1;
                repeat (20) @(negedge clk);
                chk(ir === 1'b0, "R2", "third byte refused", int'(ir), 0);
                iv = 1'b0;
            end
        join
        repeat (200) @(negedge clk);
        chk(txd === 1'b1 && te === 1'b1, "R2", "dropped byte never sent",
            int'({txd, te}), 3);

        // R9 settings changed during a frame
        lc = 6'b000011;
        dv = 16'd1;
        send(8'h96);
        expect_frame(6'b000011, 16'd1, 8'h96, "R9", 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule